// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block sits on the host side of a parallel NOR-style flash and decides whether an embedded program or erase operation has finished. After a start pulse it issues status reads over a read-request/read-data handshake. It compares the toggle bit of each pair of reads. If the toggle bit has stopped, the operation is complete. If it still toggles, the poller reads again.

When the device raises its internal limit flag while the toggle bit is still moving, one further read pair is taken. This pair separates a late completion from a real failure. A failure ends with a single reset-command write of 0xF0, which returns the device to array reads. After that the fail flag is raised. A host-side pair budget stops polling that never ends. An abort input returns the poller to idle.

Top module: `tpoll_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o`, `host_tmo_o`, `rd_req_o` and `rst_wr_req_o` are all low.
- R2: A `start_i` pulse while idle raises `busy_o` and `rd_req_o` on the next cycle. A read completes on a cycle where `rd_req_o` and `rd_valid_i` are both high. `rd_valid_i` has no effect while idle.
- R3: If bit 6 of the second read of a pair equals bit 6 of the first, the next cycle shows `done_o` high and `busy_o` low, and no further read is requested.
- R4: If bit 6 differs across the pair and bit 5 of the second read is 0, polling continues with a fresh pair. The first read of that new pair is stored, and no earlier sample is compared.
- R5: If bit 6 differs and bit 5 of the second read is 1, one more read pair is taken. If bit 6 is unchanged across that pair, the result is `done_o`.
- R6: If bit 6 still differs in that extra pair, `rst_wr_req_o` rises with `rst_wr_data_o` = 0xF0. It is held until `rst_wr_ack_i`. `fail_o` rises, and `busy_o` falls, on the cycle after the acknowledge.
- R7: A pair whose toggle bit is unchanged is reported as `done_o` even when bit 5 of the second read is 1, because the toggle bit is examined first.
- R8: `abort_i` returns the block to idle on the next cycle. It clears all result flags and the stored sample, and it takes precedence over a read completion or an acknowledge in the same cycle. A later start begins with a fresh pair.
- R9: After `MAX_PAIRS` consecutive pairs that toggle with bit 5 at 0, `host_tmo_o` rises and `busy_o` falls. No reset write is issued and `fail_o` stays low.
- R10: `done_o`, `fail_o` and `host_tmo_o` hold until the next accepted start, which clears them on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a poll while idle |
| abort_i | input | 1 | Abandon polling and return to idle |
| rd_req_o | output | 1 | Status read request, held until data is valid |
| rd_data_i | input | DW | Status read data |
| rd_valid_i | input | 1 | Read data valid |
| rst_wr_req_o | output | 1 | Reset-command write request |
| rst_wr_data_o | output | DW | Reset-command data (0xF0) |
| rst_wr_ack_i | input | 1 | Reset-command write accepted |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Device failure; reset command already written |
| host_tmo_o | output | 1 | Host pair budget exhausted |

## Verification
Three events can land in the same cycle. An abort can coincide with a read completion, and an abort can coincide with the acknowledge of the reset write. The bench drives both together and expects idle with every result flag low, which shows that abort wins. The device limit flag can also rise on the very read where toggling stops. The bench sweeps every combination of toggle values and limit flag over the first pair and the extra pair, and works out done, fail or continue arithmetically for each combination.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_RC_A,
    ST_RC_B,
    ST_RSTW
  } tpoll_st_e;
endpackage

// File: rtl/tpoll_sample.sv
module tpoll_sample (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  logic bit_i,
  output logic diff_o
);
  logic held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      held_q <= 1'b0;
    else if (clr_i)   held_q <= 1'b0;
    else if (load_i)  held_q <= bit_i;
  end

  assign diff_o = held_q ^ bit_i;
endmodule

// File: rtl/tpoll_pair_cnt.sv
module tpoll_pair_cnt #(
  parameter int unsigned MAX_PAIRS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (MAX_PAIRS > 1) ? $clog2(MAX_PAIRS) : 1;

  generate
    if (MAX_PAIRS == 0) begin : g_off
      assign last_o = 1'b0;
    end else begin : g_on
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (inc_i)  cnt_q <= cnt_q + 1'b1;
      end
      assign last_o = (cnt_q == CW'(MAX_PAIRS - 1));
    end
  endgenerate
endmodule

// File: rtl/tpoll_ctrl.sv
module tpoll_ctrl
  import tpoll_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned TOG_BIT   = 6,
  parameter int unsigned LIM_BIT   = 5,
  parameter int unsigned MAX_PAIRS = 1024,
  parameter logic [DW-1:0] RST_CMD = 8'hF0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  output logic          rd_req_o,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_valid_i,
  output logic          rst_wr_req_o,
  output logic [DW-1:0] rst_wr_data_o,
  input  logic          rst_wr_ack_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic          host_tmo_o
);
  tpoll_st_e st_q, st_d;
  logic done_q, fail_q, tmo_q;
  logic rd_fire, tog, lim, diff, last, smp_load, smp_clr, cnt_inc, cnt_clr;
  logic go;

  assign rd_req_o      = (st_q == ST_RD_A) || (st_q == ST_RD_B) ||
                         (st_q == ST_RC_A) || (st_q == ST_RC_B);
  assign rst_wr_req_o  = (st_q == ST_RSTW);
  assign rst_wr_data_o = RST_CMD;
  assign busy_o        = (st_q != ST_IDLE);

  assign rd_fire  = rd_req_o && rd_valid_i && !abort_i;
  assign tog      = rd_data_i[TOG_BIT];
  assign lim      = rd_data_i[LIM_BIT];
  assign go       = (st_q == ST_IDLE) && start_i && !abort_i;
  assign smp_load = rd_fire && ((st_q == ST_RD_A) || (st_q == ST_RC_A));
  assign smp_clr  = abort_i || (st_q == ST_IDLE);
  assign cnt_inc  = rd_fire && (st_q == ST_RD_B) && diff && !lim;
  assign cnt_clr  = abort_i || go;

  tpoll_sample u_sample (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (smp_clr),
    .load_i(smp_load),
    .bit_i (tog),
    .diff_o(diff)
  );

  tpoll_pair_cnt #(.MAX_PAIRS(MAX_PAIRS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .last_o(last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go) st_d = ST_RD_A;
      ST_RD_A: if (rd_fire) st_d = ST_RD_B;
      ST_RD_B: if (rd_fire) begin
        if (!diff)     st_d = ST_IDLE;
        else if (lim)  st_d = ST_RC_A;
        else if (last) st_d = ST_IDLE;
        else           st_d = ST_RD_A;
      end
      ST_RC_A: if (rd_fire) st_d = ST_RC_B;
      ST_RC_B: if (rd_fire) st_d = diff ? ST_RSTW : ST_IDLE;
      ST_RSTW: if (rst_wr_ack_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (abort_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (abort_i || go) begin
        done_q <= 1'b0;
        fail_q <= 1'b0;
        tmo_q  <= 1'b0;
      end else begin
        if (rd_fire && !diff && ((st_q == ST_RD_B) || (st_q == ST_RC_B)))
          done_q <= 1'b1;
        if (rd_fire && (st_q == ST_RD_B) && diff && !lim && last)
          tmo_q <= 1'b1;
        if ((st_q == ST_RSTW) && rst_wr_ack_i)
          fail_q <= 1'b1;
      end
    end
  end

  assign done_o     = done_q;
  assign fail_o     = fail_q;
  assign host_tmo_o = tmo_q;
endmodule

// File: rtl/tpoll_chk.sv
module tpoll_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          abort_i,
  input logic          rd_req_o,
  input logic          rd_valid_i,
  input logic          rst_wr_req_o,
  input logic [DW-1:0] rst_wr_data_o,
  input logic          rst_wr_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          fail_o,
  input logic          host_tmo_o
);
  assert_req_needs_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || rst_wr_req_o) |-> busy_o);

  assert_one_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && rst_wr_req_o));

  assert_rst_cmd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_wr_req_o |-> (rst_wr_data_o == DW'(8'hF0)));

  assert_rst_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_wr_req_o && !rst_wr_ack_i && !abort_i) |=> rst_wr_req_o);

  assert_fail_after_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(rst_wr_req_o && rst_wr_ack_i));

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !done_o && !fail_o && !host_tmo_o));

  assert_single_verdict_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o, host_tmo_o}));

  assert_tmo_no_fail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_tmo_o) |-> !fail_o && !busy_o);
endmodule

bind tpoll_ctrl tpoll_chk #(.DW(DW)) u_tpoll_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .abort_i      (abort_i),
  .rd_req_o     (rd_req_o),
  .rd_valid_i   (rd_valid_i),
  .rst_wr_req_o (rst_wr_req_o),
  .rst_wr_data_o(rst_wr_data_o),
  .rst_wr_ack_i (rst_wr_ack_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .host_tmo_o   (host_tmo_o)
);

// File: tb/tb_tpoll_ctrl.sv
`timescale 1ns/1ps
module tb_tpoll_ctrl;
  localparam int unsigned NP = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, abort_i = 0, rd_valid_i = 0, rst_wr_ack_i = 0;
  logic [7:0] rd_data_i = '0;
  logic rd_req_o, rst_wr_req_o, busy_o, done_o, fail_o, host_tmo_o;
  logic [7:0] rst_wr_data_o;
  int checks = 0, errors = 0;

  always #4 clk_i = ~clk_i;

  tpoll_ctrl #(.MAX_PAIRS(NP)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .rd_req_o(rd_req_o), .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i),
    .rst_wr_req_o(rst_wr_req_o), .rst_wr_data_o(rst_wr_data_o),
    .rst_wr_ack_i(rst_wr_ack_i), .busy_o(busy_o), .done_o(done_o),
    .fail_o(fail_o), .host_tmo_o(host_tmo_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sd(input bit t, input bit f);
    return {1'b0, t, f, 5'b10101};
  endfunction

  // state code: busy, done, fail, tmo, rd_req, rst_wr_req
  function automatic int flags();
    return {busy_o, done_o, fail_o, host_tmo_o, rd_req_o, rst_wr_req_o};
  endfunction

  task automatic start();
    @(negedge clk_i) start_i = 1;
    @(negedge clk_i) start_i = 0;
  endtask

  task automatic rd(input logic [7:0] d);
    for (int n = 0; n < 50 && !rd_req_o; n++) @(negedge clk_i);
    rd_valid_i = 1; rd_data_i = d;
    @(negedge clk_i) rd_valid_i = 0;
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset flags", flags(), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 after release", flags(), 0);

    // R2: valid while idle has no effect
    rd_valid_i = 1; rd_data_i = sd(1, 1);
    @(negedge clk_i) rd_valid_i = 0;
    chk("R2 idle valid ignored", flags(), 0);

    start();
    chk("R2 start busy+req", flags(), 6'b100010);

    // sweep: first pair (t1,t2,f), extra pair (r1,r2)
    for (int v = 0; v < 32; v++) begin
      bit t1, t2, f, r1, r2;
      {t1, t2, f, r1, r2} = 5'(v);
      if (v != 0) start();
      chk("R10 start clears flags", flags(), 6'b100010);
      rd(sd(t1, 0));
      chk("R2 second read requested", flags(), 6'b100010);
      rd(sd(t2, f));
      if (t1 == t2) begin
        chk(f ? "R7 stop beats limit" : "R3 stop done", flags(), 6'b010000);
      end else if (!f) begin
        chk("R4 continue", flags(), 6'b100010);
        rd(sd(t1, 0)); rd(sd(t1, 0));
        chk("R4 fresh pair done", flags(), 6'b010000);
      end else begin
        chk("R5 recheck requested", flags(), 6'b100010);
        rd(sd(r1, 1)); rd(sd(r2, 1));
        if (r1 == r2) chk("R5 recheck done", flags(), 6'b010000);
        else begin
          chk("R6 reset write", flags(), 6'b100001);
          chk("R6 reset data", int'(rst_wr_data_o), 240);
          @(negedge clk_i);
          chk("R6 held before ack", flags(), 6'b100001);
          rst_wr_ack_i = 1;
          @(negedge clk_i) rst_wr_ack_i = 0;
          chk("R6 fail after ack", flags(), 6'b001000);
        end
      end
      repeat (2) @(negedge clk_i);
      chk("R10 verdict held", int'(busy_o || rd_req_o), 0);
    end

    // R9 host timeout
    start();
    for (int p = 0; p < NP; p++) begin
      rd(sd(0, 0)); rd(sd(1, 0));
      chk("R9 pairs", flags(), (p == NP - 1) ? 6'b000100 : 6'b100010);
    end

    // R9 count restarts on new start: NP-1 toggling pairs then stop
    start();
    for (int p = 0; p < NP - 1; p++) begin rd(sd(1, 0)); rd(sd(0, 0)); end
    rd(sd(0, 0)); rd(sd(0, 0));
    chk("R9 counter reset by start", flags(), 6'b010000);

    // R8 abort with read completion
    start();
    rd(sd(0, 0));
    @(negedge clk_i) begin abort_i = 1; rd_valid_i = 1; rd_data_i = sd(0, 0); end
    @(negedge clk_i) begin abort_i = 0; rd_valid_i = 0; end
    chk("R8 abort beats read", flags(), 0);
    start();
    rd(sd(1, 0)); rd(sd(1, 0));
    chk("R8 fresh pair after abort", flags(), 6'b010000);

    // R8 abort with reset ack
    start();
    rd(sd(0, 0)); rd(sd(1, 1)); rd(sd(0, 1)); rd(sd(1, 1));
    chk("R8 in reset write", flags(), 6'b100001);
    @(negedge clk_i) begin abort_i = 1; rst_wr_ack_i = 1; end
    @(negedge clk_i) begin abort_i = 0; rst_wr_ack_i = 0; end
    chk("R8 abort beats ack", flags(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule